// File: doc/BRIEF.md
# Flash Embedded Operation Status Generator

This block is a synchronous model of the status path inside a parallel NOR flash device. A bus-cycle command decoder upstream presents one-cycle pulses for byte program, chip erase, sector erase, erase suspend and erase resume. Each pulse reaches the block on the cycle in which the final write strobe of its command sequence completes. From that point the block runs a busy counter that stands in for the embedded algorithm. While the counter runs, host reads get a status word in place of array data.

The status word carries two bits. The top bit is a polling bit: during a program it is the inverse of bit 7 of the byte being written, and during an erase it is 0. The next bit flips on every status read. An open-drain ready/busy enable is asserted while an algorithm runs. An erase can be suspended so that the array can be read, and a byte program can run inside the suspend. A later resume continues the erase with the cycles it still has left.

A read that hits a protected sector during an operation gets array data back and raises a debug flag. On the read that lands in the final busy cycle, only the polling bit already shows its final value. The next read returns plain array data.

Top module: `flash_opstat_top`

States:
- `ST_IDLE`: no operation is running.
- `ST_PROG`: a byte program is running.
- `ST_ERASE`: a sector or chip erase is running.
- `ST_SUSP`: an erase is suspended.
- `ST_SUSP_PROG`: a byte program is running inside an erase suspend.

Transitions:
- `ST_IDLE` goes to `ST_PROG` on a program command. It goes to `ST_ERASE` on a chip or sector erase command. Program takes priority, then chip erase, then sector erase.
- `ST_PROG` goes to `ST_IDLE` when the program counter expires.
- `ST_ERASE` goes to `ST_IDLE` when the erase counter expires. Otherwise it goes to `ST_SUSP` on a suspend command.
- `ST_SUSP` goes to `ST_SUSP_PROG` on a program command. Otherwise it goes to `ST_ERASE` on a resume command.
- `ST_SUSP_PROG` goes to `ST_SUSP` when the program counter expires.

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves the block idle. After that edge `rb_drive_low` is 0, `dq_out` is 0 and `prot_dbg` is 0.
- R2: A program command accepted while idle holds `rb_drive_low` high for exactly PROG_CYC cycles, starting the cycle after the command. It then releases.
- R3: During a program, a read returns a status word in `dq_out` on the cycle after `rd_strobe`. Bit 7 is the inverse of bit 7 of the programmed byte, and bits 5..0 are 0.
- R4: During an erase, a read returns a status word with bit 7 equal to 0 and bits 5..0 equal to 0.
- R5: Bit 6 of successive status reads alternates, whatever the cycles that pass between the reads.
- R6: A sector erase holds `rb_drive_low` high for SECT_CYC cycles. A chip erase holds it high for CHIP_CYC cycles.
- R7: A suspend during an erase releases `rb_drive_low` from the next cycle and pauses the erase counter. Reads in suspend return `array_data`. A resume continues the erase, so the busy cycles of the erase still total SECT_CYC or CHIP_CYC.
- R8: A resume while an erase is running (not suspended) has no effect. A suspend issued after a resume is accepted again.
- R9: A program issued during an erase suspend holds `rb_drive_low` high for PROG_CYC cycles. The block then returns to the suspended erase: `rb_drive_low` is released and reads return array data.
- R10: A read sampled in the last busy cycle of an operation returns the final polling bit in bit 7: the true bit 7 of the programmed byte for a program, and 1 for an erase. Bits 5..0 remain 0. The next read returns `array_data`.
- R11: A read with `rd_prot` high during an operation returns `array_data` and sets `prot_dbg`. Any read with `rd_prot` low clears `prot_dbg`.
- R12: Program and erase commands issued while an operation runs are ignored, and so is a suspend issued while a program runs. The duration of the running operation and its polling data do not change.
- R13: A read while idle or suspended returns `array_data`. `dq_out` holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_prog | input | 1 | Byte program command pulse |
| prog_data | input | 8 | Byte being programmed, sampled together with `cmd_prog` |
| cmd_chip_erase | input | 1 | Chip erase command pulse |
| cmd_sect_erase | input | 1 | Sector erase command pulse |
| cmd_suspend | input | 1 | Erase suspend command pulse |
| cmd_resume | input | 1 | Erase resume command pulse (address is not used) |
| rd_strobe | input | 1 | Host read cycle |
| rd_prot | input | 1 | Read address lies in a protected sector |
| array_data | input | 8 | Array contents at the read address |
| dq_out | output | 8 | Read data bus, registered |
| rb_drive_low | output | 1 | Open-drain ready/busy pull-down enable (1 = busy) |
| prot_dbg | output | 1 | Last read during an operation hit a protected sector |

## Verification
The checker looks at every cycle. It confirms the reset state, that a program command always raises busy, that status words have zero low bits, the setting and clearing of the protection flag, and that the data bus holds between reads. Other behaviour only shows across whole scenarios, which the bench drives against its reference model:
- exact busy durations across suspend and resume,
- alternation of the toggle bit,
- the completion-read corner,
- the rule that a running operation ignores new commands.

// File: rtl/flash_opstat_pkg.sv
package flash_opstat_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_SUSP,
        ST_SUSP_PROG
    } op_state_t;

endpackage

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // expires in the cycle in which the last busy count is consumed
    assign done = run && (cnt_q == CW'(1));
endmodule

// File: rtl/flash_status_fsm.sv
module flash_status_fsm
    import flash_opstat_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_prog,
    input  logic      cmd_chip_erase,
    input  logic      cmd_sect_erase,
    input  logic      cmd_suspend,
    input  logic      cmd_resume,
    input  logic      prog_done,
    input  logic      erase_done,
    output op_state_t state,
    output logic      prog_load,
    output logic      erase_load,
    output logic      erase_is_chip,
    output logic      prog_run,
    output logic      erase_run,
    output logic      busy,
    output logic      done_now
);
    op_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_prog) begin
                    state_d = ST_PROG;
                end else if (cmd_chip_erase || cmd_sect_erase) begin
                    state_d = ST_ERASE;
                end
            end
            ST_PROG: begin
                if (prog_done) state_d = ST_IDLE;
            end
            ST_ERASE: begin
                if (erase_done) begin
                    state_d = ST_IDLE;
                end else if (cmd_suspend) begin
                    state_d = ST_SUSP;
                end
            end
            ST_SUSP: begin
                if (cmd_prog) begin
                    state_d = ST_SUSP_PROG;
                end else if (cmd_resume) begin
                    state_d = ST_ERASE;
                end
            end
            ST_SUSP_PROG: begin
                if (prog_done) state_d = ST_SUSP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        prog_load     = 1'b0;
        erase_load    = 1'b0;
        erase_is_chip = cmd_chip_erase;
        prog_run      = 1'b0;
        erase_run     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                prog_load  = cmd_prog;
                erase_load = !cmd_prog && (cmd_chip_erase || cmd_sect_erase);
            end
            ST_PROG:      prog_run  = 1'b1;
            ST_ERASE:     erase_run = 1'b1;
            ST_SUSP:      prog_load = cmd_prog;
            ST_SUSP_PROG: prog_run  = 1'b1;
            default: ;
        endcase
        busy     = prog_run || erase_run;
        done_now = (prog_run && prog_done) || (erase_run && erase_done);
    end

    assign state = state_q;
endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_strobe,
    input  logic          rd_prot,
    input  logic [DW-1:0] array_data,
    input  logic          busy,
    input  logic          kind_prog,
    input  logic          done_now,
    input  logic [DW-1:0] prog_byte,
    output logic [DW-1:0] dq_out,
    output logic          prot_dbg
);
    localparam int POLL_BIT = DW - 1;
    localparam int TOG_BIT  = DW - 2;

    logic          tog_q;
    logic          poll_val;
    logic [DW-1:0] status_word;

    always_comb begin
        if (kind_prog) poll_val = done_now ? prog_byte[POLL_BIT] : !prog_byte[POLL_BIT];
        else           poll_val = done_now;
        status_word           = '0;
        status_word[POLL_BIT] = poll_val;
        status_word[TOG_BIT]  = !tog_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dq_out   <= '0;
            tog_q    <= 1'b0;
            prot_dbg <= 1'b0;
        end else if (rd_strobe) begin
            if (busy && !rd_prot) begin
                tog_q    <= !tog_q;
                dq_out   <= status_word;
                prot_dbg <= 1'b0;
            end else begin
                dq_out   <= array_data;
                prot_dbg <= busy && rd_prot;
            end
        end
    end
endmodule

// File: rtl/flash_opstat_top.sv
module flash_opstat_top
    import flash_opstat_pkg::*;
#(
    parameter int PROG_CYC = 6,
    parameter int SECT_CYC = 20,
    parameter int CHIP_CYC = 40
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_prog,
    input  logic [7:0] prog_data,
    input  logic       cmd_chip_erase,
    input  logic       cmd_sect_erase,
    input  logic       cmd_suspend,
    input  logic       cmd_resume,
    input  logic       rd_strobe,
    input  logic       rd_prot,
    input  logic [7:0] array_data,
    output logic [7:0] dq_out,
    output logic       rb_drive_low,
    output logic       prot_dbg
);
    localparam int DW    = 8;
    localparam int MAXE  = (CHIP_CYC > SECT_CYC) ? CHIP_CYC : SECT_CYC;
    localparam int MAXC  = (MAXE > PROG_CYC) ? MAXE : PROG_CYC;
    localparam int CW    = $clog2(MAXC + 1);

    op_state_t     state;
    logic          prog_load, erase_load, erase_is_chip;
    logic          prog_run, erase_run, busy, done_now;
    logic          prog_done, erase_done;
    logic [DW-1:0] prog_byte_q;
    logic [CW-1:0] erase_len;

    flash_status_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .cmd_prog      (cmd_prog),
        .cmd_chip_erase(cmd_chip_erase),
        .cmd_sect_erase(cmd_sect_erase),
        .cmd_suspend   (cmd_suspend),
        .cmd_resume    (cmd_resume),
        .prog_done     (prog_done),
        .erase_done    (erase_done),
        .state         (state),
        .prog_load     (prog_load),
        .erase_load    (erase_load),
        .erase_is_chip (erase_is_chip),
        .prog_run      (prog_run),
        .erase_run     (erase_run),
        .busy          (busy),
        .done_now      (done_now)
    );

    assign erase_len = erase_is_chip ? CW'(CHIP_CYC) : CW'(SECT_CYC);

    flash_busy_timer #(.CW(CW)) u_prog_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (prog_load),
        .load_val(CW'(PROG_CYC)),
        .run     (prog_run),
        .done    (prog_done)
    );

    flash_busy_timer #(.CW(CW)) u_erase_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (erase_load),
        .load_val(erase_len),
        .run     (erase_run),
        .done    (erase_done)
    );

    always_ff @(posedge clk) begin
        if (rst)            prog_byte_q <= '0;
        else if (prog_load) prog_byte_q <= prog_data;
    end

    flash_read_mux #(.DW(DW)) u_rdmux (
        .clk       (clk),
        .rst       (rst),
        .rd_strobe (rd_strobe),
        .rd_prot   (rd_prot),
        .array_data(array_data),
        .busy      (busy),
        .kind_prog (prog_run),
        .done_now  (done_now),
        .prog_byte (prog_byte_q),
        .dq_out    (dq_out),
        .prot_dbg  (prot_dbg)
    );

    assign rb_drive_low = busy;
endmodule

// File: rtl/flash_opstat_chk.sv
module flash_opstat_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_prog,
    input logic       rd_strobe,
    input logic       rd_prot,
    input logic [7:0] dq_out,
    input logic       rb_drive_low,
    input logic       prot_dbg
);
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!rb_drive_low && dq_out == 8'h00 && !prot_dbg)); // R1

    AST_PROG_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!rb_drive_low && cmd_prog) |=> rb_drive_low); // R2

    AST_STATUS_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && rb_drive_low && !rd_prot) |=> (dq_out[5:0] == 6'b0)); // R3

    AST_PROT_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && rd_prot && rb_drive_low) |=> prot_dbg); // R11

    AST_PROT_FLAG_CLR: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !rd_prot) |=> !prot_dbg); // R11

    AST_DQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe |=> $stable(dq_out)); // R13
endmodule

bind flash_opstat_top flash_opstat_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .cmd_prog    (cmd_prog),
    .rd_strobe   (rd_strobe),
    .rd_prot     (rd_prot),
    .dq_out      (dq_out),
    .rb_drive_low(rb_drive_low),
    .prot_dbg    (prot_dbg)
);

// File: tb/flash_opstat_top_tb_top.sv
module flash_opstat_top_tb_top;
    localparam int PC = 6;
    localparam int SC = 20;
    localparam int CC = 40;
    localparam int S_IDLE = 0, S_PROG = 1, S_ERASE = 2, S_SUSP = 3, S_SPROG = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_prog = 0, cmd_chip_erase = 0, cmd_sect_erase = 0;
    logic       cmd_suspend = 0, cmd_resume = 0, rd_strobe = 0, rd_prot = 0;
    logic [7:0] prog_data = 0, array_data = 0;
    logic [7:0] dq_out;
    logic       rb_drive_low, prot_dbg;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    flash_opstat_top #(.PROG_CYC(PC), .SECT_CYC(SC), .CHIP_CYC(CC)) dut_i (
        .clk(clk), .rst(rst), .cmd_prog(cmd_prog), .prog_data(prog_data),
        .cmd_chip_erase(cmd_chip_erase), .cmd_sect_erase(cmd_sect_erase),
        .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume),
        .rd_strobe(rd_strobe), .rd_prot(rd_prot), .array_data(array_data),
        .dq_out(dq_out), .rb_drive_low(rb_drive_low), .prot_dbg(prot_dbg)
    );

    // reference model built from the requirements
    int       ms = S_IDLE, mp = 0, me = 0;
    bit [7:0] mb = 0, mdq = 0;
    bit       mtog = 0, mprot = 0;

    function automatic bit m_busy(int s);
        return (s == S_PROG) || (s == S_ERASE) || (s == S_SPROG);
    endfunction

    function automatic bit [7:0] m_status(bit final_bit, bit tog);
        return {final_bit, tog, 6'b0};
    endfunction

    always @(posedge clk) begin
        bit pk, dn;
        if (rst) begin
            ms = S_IDLE; mp = 0; me = 0; mb = 0; mtog = 0; mdq = 0; mprot = 0;
        end else begin
            pk = (ms == S_PROG) || (ms == S_SPROG);
            dn = pk ? (mp == 1) : ((ms == S_ERASE) && (me == 1));
            if (rd_strobe) begin
                if (m_busy(ms) && !rd_prot) begin
                    mtog  = !mtog;
                    mdq   = m_status(pk ? (dn ? mb[7] : !mb[7]) : dn, mtog);
                    mprot = 0;
                end else begin
                    mdq   = array_data;
                    mprot = m_busy(ms) && rd_prot;
                end
            end
            case (ms)
                S_IDLE: begin
                    if (cmd_prog) begin ms = S_PROG; mp = PC; mb = prog_data; end
                    else if (cmd_chip_erase) begin ms = S_ERASE; me = CC; end
                    else if (cmd_sect_erase) begin ms = S_ERASE; me = SC; end
                end
                S_PROG:  if (mp == 1) begin ms = S_IDLE; mp = 0; end else mp--;
                S_ERASE: begin
                    if (me == 1) begin ms = S_IDLE; me = 0; end
                    else begin me--; if (cmd_suspend) ms = S_SUSP; end
                end
                S_SUSP: begin
                    if (cmd_prog) begin ms = S_SPROG; mp = PC; mb = prog_data; end
                    else if (cmd_resume) ms = S_ERASE;
                end
                S_SPROG: if (mp == 1) begin ms = S_SUSP; mp = 0; end else mp--;
                default: ms = S_IDLE;
            endcase
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // advance one cycle, then compare every output with the model
    task automatic step(string tag);
        @(negedge clk);
        chk({tag, " dq_out"}, dq_out, mdq);
        chk({tag, " rb_drive_low"}, rb_drive_low, m_busy(ms));
        chk({tag, " prot_dbg"}, prot_dbg, mprot);
        cmd_prog = 0; cmd_chip_erase = 0; cmd_sect_erase = 0;
        cmd_suspend = 0; cmd_resume = 0; rd_strobe = 0; rd_prot = 0;
    endtask

    // step until busy releases, returning the busy cycles seen
    task automatic run_out(string tag, inout int cnt);
        int guard = 0;
        while (rb_drive_low && guard < 200) begin
            step(tag);
            if (rb_drive_low) cnt++;
            guard++;
        end
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            finish_run();
        end
    end

    initial begin
        int  busy_n, d6;
        void'($urandom(32'd20250611));
        @(negedge clk);
        step("R1"); step("R1");
        rst = 0;
        chk("R1 dq_out", dq_out, 0);
        chk("R1 rb_drive_low", rb_drive_low, 0);
        chk("R1 prot_dbg", prot_dbg, 0);

        // R13: idle read
        rd_strobe = 1; array_data = 8'h3C; step("R13");
        chk("R13 idle read", dq_out, 8'h3C);
        step("R13");
        chk("R13 hold", dq_out, 8'h3C);

        // R2/R3/R5: program and its duration
        cmd_prog = 1; prog_data = 8'hA5; step("R2");
        busy_n = rb_drive_low;
        rd_strobe = 1; step("R3");
        busy_n += rb_drive_low;
        chk("R3 poll bit", dq_out[7], 0);
        chk("R3 low bits", dq_out[5:0], 0);
        d6 = dq_out[6];
        step("R5"); busy_n += rb_drive_low;
        rd_strobe = 1; step("R5"); busy_n += rb_drive_low;
        chk("R5 toggle", dq_out[6], !d6);
        run_out("R2", busy_n);
        chk("R2 program busy cycles", busy_n, PC);

        // R10: read in the last busy cycle
        cmd_prog = 1; prog_data = 8'h80; step("R10");
        for (int i = 0; i < PC - 1; i++) step("R10");
        rd_strobe = 1; array_data = 8'h11; step("R10");
        chk("R10 final poll bit", dq_out[7], 1);
        chk("R10 low bits", dq_out[5:0], 0);
        chk("R10 released", rb_drive_low, 0);
        rd_strobe = 1; array_data = 8'h5A; step("R10");
        chk("R10 next read", dq_out, 8'h5A);

        // R4/R6: sector erase
        cmd_sect_erase = 1; step("R6");
        busy_n = rb_drive_low;
        rd_strobe = 1; step("R4"); busy_n += rb_drive_low;
        chk("R4 erase poll bit", dq_out[7], 0);
        run_out("R6", busy_n);
        chk("R6 sector busy cycles", busy_n, SC);

        // R6/R11/R12: chip erase with protected read and ignored commands
        cmd_chip_erase = 1; step("R6");
        busy_n = rb_drive_low;
        rd_strobe = 1; rd_prot = 1; array_data = 8'h77; step("R11"); busy_n += rb_drive_low;
        chk("R11 protected data", dq_out, 8'h77);
        chk("R11 flag set", prot_dbg, 1);
        rd_strobe = 1; step("R11"); busy_n += rb_drive_low;
        chk("R11 flag clear", prot_dbg, 0);
        cmd_prog = 1; prog_data = 8'h00; cmd_sect_erase = 1; step("R12"); busy_n += rb_drive_low;
        run_out("R6", busy_n);
        chk("R6 chip busy cycles", busy_n, CC);

        // R12: commands during a program
        cmd_prog = 1; prog_data = 8'h7F; step("R12");
        busy_n = rb_drive_low;
        cmd_prog = 1; prog_data = 8'hFF; cmd_chip_erase = 1; cmd_suspend = 1; step("R12");
        busy_n += rb_drive_low;
        rd_strobe = 1; step("R12"); busy_n += rb_drive_low;
        chk("R12 poll keeps first data", dq_out[7], 1);
        run_out("R12", busy_n);
        chk("R12 program busy cycles", busy_n, PC);

        // R7/R8/R9: suspend, program in suspend, resume
        cmd_sect_erase = 1; step("R7");
        busy_n = rb_drive_low;
        for (int i = 0; i < 4; i++) begin step("R7"); busy_n += rb_drive_low; end
        cmd_suspend = 1; step("R7"); busy_n += rb_drive_low;
        chk("R7 released in suspend", rb_drive_low, 0);
        rd_strobe = 1; array_data = 8'hC3; step("R7");
        chk("R7 suspend read", dq_out, 8'hC3);
        cmd_prog = 1; prog_data = 8'h01; step("R9");
        d6 = rb_drive_low;
        run_out("R9", d6);
        chk("R9 suspend program cycles", d6, PC);
        rd_strobe = 1; array_data = 8'h9E; step("R9");
        chk("R9 back in suspend", dq_out, 8'h9E);
        chk("R9 released", rb_drive_low, 0);
        cmd_resume = 1; step("R8"); busy_n += rb_drive_low;
        cmd_resume = 1; step("R8"); busy_n += rb_drive_low;
        chk("R8 resume ignored while erasing", rb_drive_low, 1);
        cmd_suspend = 1; step("R8"); busy_n += rb_drive_low;
        chk("R8 re-suspend", rb_drive_low, 0);
        step("R8");
        cmd_resume = 1; step("R7"); busy_n += rb_drive_low;
        run_out("R7", busy_n);
        chk("R7 total erase cycles", busy_n, SC);

        // constrained random against the model
        for (int i = 0; i < 4000; i++) begin
            rd_strobe      = ($urandom % 100) < 40;
            rd_prot        = ($urandom % 100) < 10;
            array_data     = 8'($urandom);
            prog_data      = 8'($urandom);
            cmd_prog       = ($urandom % 100) < 4;
            cmd_chip_erase = ($urandom % 100) < 1;
            cmd_sect_erase = ($urandom % 100) < 3;
            cmd_suspend    = ($urandom % 100) < 5;
            cmd_resume     = ($urandom % 100) < 5;
            rst            = ($urandom % 1000) < 2;
            step(rst ? "R1" : "R12");
            rst = 0;
        end
        finish_run();
    end
endmodule